// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block sits on a small 32-bit register bus and gives software a pointer/data pair through which it can reach either video memory or any other register indirectly. Software first writes a pointer word to the index register. Accesses to the four-byte data port are then redirected. When pointer bit 31 is set, the data-port access goes to a memory port at the pointer address with bit 31 removed. When bit 31 is clear, the access is sent back into the register decoder at the pointer address plus the byte offset within the data port.

Host accesses to any other bus address go straight to the register port, so the same register file serves direct and indirect traffic. Accesses may be 1, 2 or 4 bytes wide. Host data is right-aligned on the bus, and the block moves it onto the correct byte lanes. Memory accesses that would run past the end of memory are dropped. Pointers that would loop back onto the window itself are refused, and a sticky error flag records the refusal.

Top module: `idx_window`

## Requirements
- R1: A write to the index register (bus address INDEX_ADDR) stores the written word with bits 1:0 forced to zero. A read of that address returns the stored word.
- R2: With pointer bit 31 set, a data-port access performs one little-endian memory transaction at byte address pointer[30:0], with the host size. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Byte k of the access sits on data bits 8k+7:8k. Read data is zero-extended.
- R3: The memory transaction is issued only when pointer[30:0] + size ≤ MEM_BYTES. Otherwise no memory transaction occurs, a read returns 0 and a write changes nothing.
- R4: With pointer bit 31 clear and the pointer above DATA_ADDR+3, a data-port access at byte offset o (bus address DATA_ADDR+o) becomes one register-port transaction at byte address pointer+o.
- R5: With pointer bit 31 clear and the pointer at or below DATA_ADDR+3, a data-port access issues no transaction, a read returns 0, and the error flag is set.
- R6: A register transaction at byte address t uses lane offset t[1:0]. Write data is shifted up by 8·offset bits and the byte enables cover size bytes from that lane. Read data is shifted down by 8·offset bits and masked to size bytes. A 4-byte access at lane 0 replaces the whole word.
- R7: Every host access completes with a one-cycle hostReady pulse and causes at most one forwarded transaction. Register and refused accesses complete one cycle after the request. Memory accesses complete one cycle after memReady.
- R8: The error flag stays set across later accesses until the index register is read, which clears it.
- R9: A host access to an address that is neither the index register nor the data port is forwarded to the register port at that address, with the lane rules of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Host byte address |
| hostSize | input | 2 | Access size code |
| hostWdata | input | 32 | Right-aligned write data |
| hostReady | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Right-aligned read data, valid with hostReady |
| errFlag | output | 1 | Sticky refused-pointer flag |
| regValid | output | 1 | Register-port transaction strobe |
| regWrite | output | 1 | Register-port write |
| regAddr | output | ADDR_W | Word-aligned register byte address |
| regByteEn | output | 4 | Register byte-lane enables |
| regWdata | output | 32 | Lane-placed register write data |
| regRdata | input | 32 | Register read word, same cycle |
| memValid | output | 1 | Memory request, held until memReady |
| memWrite | output | 1 | Memory write |
| memAddr | output | MEM_AW | Memory byte address |
| memSize | output | 2 | Memory access size code |
| memWdata | output | 32 | Right-aligned memory write data |
| memRdata | input | 32 | Right-aligned memory read data |
| memReady | input | 1 | Memory completion |

## Verification
The bench builds the block with ADDR_W = 8, DATA_ADDR = 4 and MEM_BYTES = 62. An 8-bit register space can be swept word by word through both the window and the direct path. A memory size that is not a power of two puts the bounds edge at pointer 60, where 1- and 2-byte accesses fit but a 4-byte access does not. The pointers 0 and 4 exercise the refused range, and 8 is the first accepted pointer. Memory is modelled with a three-cycle latency so that completion timing for memory and register paths can be told apart.

// File: rtl/idx_window_pkg.sv
package idx_window_pkg;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic useIdx;
    logic capReg;
    logic capMem;
    logic capZero;
    logic setErr;
  } winStrb_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] sizeLanes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/idx_window_ctrl.sv
module idx_window_ctrl
  import idx_window_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int INDEX_ADDR = 0,
  parameter int DATA_ADDR  = 4,
  parameter int MEM_BYTES  = 16777216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       idxReg,
  input  logic              memReady,
  output logic              hostReady,
  output logic              regValid,
  output logic              regWrite,
  output logic              memValid,
  output logic              memWrite,
  output winStrb_t          strb
);

  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(INDEX_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
  localparam logic [31:0]       DATA_HI = 32'(DATA_ADDR + 3);
  localparam logic [32:0]       MEM_LIM = 33'(MEM_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DONE} winState_e;
  winState_e state, stateNxt;

  logic        isIdx, isData, start, memSel, memOk, regIndOk, regDir, regGo;
  logic [32:0] memEnd;

  always_comb begin
    isIdx    = (hostAddr == IDX_A);
    isData   = (hostAddr[ADDR_W-1:2] == DATA_A[ADDR_W-1:2]);
    start    = hostValid && (state == S_IDLE);
    memEnd   = {2'b00, idxReg[30:0]} + 33'(sizeBytes(hostSize));
    memSel   = isData && idxReg[31];
    memOk    = (memEnd <= MEM_LIM);
    regIndOk = isData && !idxReg[31] && (idxReg > DATA_HI);
    regDir   = !isIdx && !isData;
    regGo    = start && (regDir || regIndOk);
  end

  always_comb begin
    strb         = '0;
    strb.idxWr   = start && isIdx && hostWrite;
    strb.idxRd   = start && isIdx && !hostWrite;
    strb.useIdx  = isData;
    strb.capReg  = regGo && !hostWrite;
    strb.capMem  = (state == S_MEM) && memReady && !hostWrite;
    strb.capZero = start && isData && !hostWrite && !regIndOk && !(memSel && memOk);
    strb.setErr  = start && isData && !idxReg[31] && !regIndOk;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE: if (start) stateNxt = (memSel && memOk) ? S_MEM : S_DONE;
      S_MEM:  if (memReady) stateNxt = S_DONE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNxt;
  end

  assign hostReady = (state == S_DONE);
  assign regValid  = regGo;
  assign regWrite  = regGo && hostWrite;
  assign memValid  = (state == S_MEM);
  assign memWrite  = memValid && hostWrite;

  // R7: completion is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hostReady |=> !hostReady);
  // R7: never two forwarded transactions at once
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(regValid && memValid));
  // R7: memory request is held until the memory answers
  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> memValid && $stable(idxReg));
  // R3: no memory request past the end of memory
  a_r3_mem_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> ({2'b00, idxReg[30:0]} + 33'(sizeBytes(hostSize))) <= MEM_LIM);
  // R5: the register port is never driven from a refused pointer
  a_r5_no_loop: assert property (@(posedge clk) disable iff (!rst_n)
    regValid && isData |-> !idxReg[31] && idxReg > DATA_HI);

endmodule

// File: rtl/idx_window_dpath.sv
module idx_window_dpath
  import idx_window_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  winStrb_t          strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  input  logic [31:0]       regRdata,
  input  logic [31:0]       memRdata,
  output logic [31:0]       idxReg,
  output logic              errFlag,
  output logic [31:0]       hostRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic [3:0]        regByteEn,
  output logic [31:0]       regWdata,
  output logic [MEM_AW-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata
);

  logic [ADDR_W-1:0] tgtAddr;
  logic [1:0]        lane;
  logic [31:0]       regRdLane;

  always_comb begin
    tgtAddr   = strb.useIdx ? (idxReg[ADDR_W-1:0] + ADDR_W'(hostAddr[1:0])) : hostAddr;
    lane      = tgtAddr[1:0];
    regAddr   = {tgtAddr[ADDR_W-1:2], 2'b00};
    regByteEn = sizeLanes(hostSize) << lane;
    regWdata  = hostWdata << {lane, 3'b000};
    regRdLane = (regRdata >> {lane, 3'b000}) & sizeMask(hostSize);
  end

  assign memAddr  = idxReg[MEM_AW-1:0];
  assign memSize  = hostSize;
  assign memWdata = hostWdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxReg    <= '0;
      errFlag   <= 1'b0;
      hostRdata <= '0;
    end else begin
      if (strb.idxWr)       idxReg  <= {hostWdata[31:2], 2'b00};
      if (strb.setErr)      errFlag <= 1'b1;
      else if (strb.idxRd)  errFlag <= 1'b0;
      if (strb.idxRd)       hostRdata <= idxReg;
      else if (strb.capReg) hostRdata <= regRdLane;
      else if (strb.capMem) hostRdata <= memRdata & sizeMask(hostSize);
      else if (strb.capZero) hostRdata <= '0;
    end
  end

  // R8: the flag only drops on an index read
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag && !strb.idxRd |=> errFlag);
  // R1: a stored pointer is always word aligned after a pointer write
  a_r1_index_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    strb.idxWr |=> idxReg[31:2] == $past(hostWdata[31:2]) && idxReg[1:0] == 2'b00);

endmodule

// File: rtl/idx_window.sv
module idx_window
  import idx_window_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int INDEX_ADDR = 0,
  parameter int DATA_ADDR  = 4,
  parameter int MEM_BYTES  = 16777216,
  localparam int MEM_AW    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  output logic              hostReady,
  output logic [31:0]       hostRdata,
  output logic              errFlag,
  output logic              regValid,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [3:0]        regByteEn,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [MEM_AW-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady
);

  winStrb_t    strb;
  logic [31:0] idxReg;

  idx_window_ctrl #(
    .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR),
    .DATA_ADDR(DATA_ADDR), .MEM_BYTES(MEM_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize),
    .idxReg(idxReg), .memReady(memReady),
    .hostReady(hostReady), .regValid(regValid), .regWrite(regWrite),
    .memValid(memValid), .memWrite(memWrite), .strb(strb)
  );

  idx_window_dpath #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .regRdata(regRdata), .memRdata(memRdata),
    .idxReg(idxReg), .errFlag(errFlag), .hostRdata(hostRdata),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWdata(regWdata),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata)
  );

endmodule

// File: tb/idx_window_bench.sv
`timescale 1ns/1ps
module idx_window_bench;

  localparam int AW = 8;
  localparam int MB = 62;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic hostValid = 0, hostWrite = 0;
  logic [AW-1:0] hostAddr = 0;
  logic [1:0] hostSize = 0;
  logic [31:0] hostWdata = 0;
  logic hostReady, errFlag, regValid, regWrite, memValid, memWrite;
  logic [31:0] hostRdata, regWdata, memWdata;
  logic [31:0] regRdata, memRdata;
  logic [AW-1:0] regAddr;
  logic [3:0] regByteEn;
  logic [5:0] memAddr;
  logic [1:0] memSize;
  logic memReady = 0;

  int checks = 0, errors = 0;
  int regCount = 0, memCount = 0;
  logic [31:0] rf [64];
  logic [31:0] rfSh [64];
  logic [7:0]  mem [64];
  logic [7:0]  memSh [64];
  int latCnt = 0;

  always #10 clk = ~clk;

  idx_window #(.ADDR_W(AW), .INDEX_ADDR(0), .DATA_ADDR(4), .MEM_BYTES(MB)) u_idx_window (
    .clk(clk), .rst_n(rst_n), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRdata(hostRdata), .errFlag(errFlag),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(regRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady)
  );

  assign regRdata = rf[regAddr[7:2]];

  always @(posedge clk) begin
    if (regValid) begin
      regCount <= regCount + 1;
      if (regWrite)
        for (int k = 0; k < 4; k++)
          if (regByteEn[k]) rf[regAddr[7:2]][8*k +: 8] <= regWdata[8*k +: 8];
    end
  end

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (memValid && !memReady) begin
      if (latCnt == LAT - 1) begin
        latCnt <= 0;
        memReady <= 1;
        memCount <= memCount + 1;
        memRdata <= 0;
        for (int k = 0; k < nBytes(memSize); k++) begin
          if (memWrite) mem[(memAddr + k) % 64] <= memWdata[8*k +: 8];
          else memRdata[8*k +: 8] <= mem[(memAddr + k) % 64];
        end
      end else latCnt <= latCnt + 1;
    end else memReady <= 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    hostValid = 1; hostWrite = wr; hostAddr = addr; hostSize = sz; hostWdata = wd;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!hostReady && cyc < 64);
    if (!hostReady) begin
      errors++; checks++;
      $display("FAIL R7 access timeout actual=%0d expected=ready", cyc);
    end
    rd = hostRdata;
    hostValid = 0;
  endtask

  function automatic logic [31:0] memExp(input int a, input logic [1:0] sz);
    logic [31:0] v = 0;
    if (a + nBytes(sz) > MB) return 0;
    for (int k = 0; k < nBytes(sz); k++) v[8*k +: 8] = memSh[a + k];
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, w, m;
    int cyc, rc, mc;
    for (int i = 0; i < 64; i++) begin rf[i] = 0; rfSh[i] = 0; mem[i] = 0; memSh[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R7 reset ready", {31'b0, hostReady}, 0);
    chk("R8 reset err", {31'b0, errFlag}, 0);
    chk("R7 reset memValid", {31'b0, memValid}, 0);
    rst_n = 1;

    access(0, 0, 2, 0, rd, cyc);
    chk("R1 reset index", rd, 0);
    access(1, 0, 2, 32'h8000_0037, rd, cyc);
    access(0, 0, 2, 0, rd, cyc);
    chk("R1 low bits cleared", rd, 32'h8000_0034);

    // R2: fill memory word by word
    for (int a = 0; a < 60; a += 4) begin
      w = 32'hA5C3_1E00 ^ (a * 32'h0103_0507);
      access(1, 0, 2, 32'h8000_0000 | a, rd, cyc);
      mc = memCount;
      access(1, 4, 2, w, rd, cyc);
      for (int k = 0; k < 4; k++) memSh[a + k] = w[8*k +: 8];
      chk("R7 mem latency", cyc, LAT + 2);
      chk("R2 one mem write", memCount - mc, 1);
    end
    // R3: edge at 60 for MEM_BYTES=62
    access(1, 0, 2, 32'h8000_003C, rd, cyc);
    access(1, 4, 1, 32'h0000_BEEF, rd, cyc);
    memSh[60] = 8'hEF; memSh[61] = 8'hBE;
    mc = memCount;
    access(1, 4, 2, 32'h1122_3344, rd, cyc);
    chk("R3 oversize write dropped", memCount - mc, 0);
    chk("R3 dropped completes fast", cyc, 1);
    access(0, 4, 2, 0, rd, cyc);
    chk("R3 oversize read zero", rd, 0);
    // R2: read back every word with every size
    for (int a = 0; a <= 60; a += 4)
      for (int s = 0; s < 3; s++) begin
        access(1, 0, 2, 32'h8000_0000 | a, rd, cyc);
        access(0, 4 + (a % 4), 2'(s), 0, rd, cyc);
        chk($sformatf("R2 mem read a=%0d s=%0d", a, s), rd, memExp(a, 2'(s)));
      end
    access(1, 0, 2, 32'hFFFF_FFFC, rd, cyc);
    mc = memCount;
    access(0, 4, 0, 0, rd, cyc);
    chk("R3 far index read zero", rd, 0);
    chk("R3 far index no mem", memCount - mc, 0);

    // R4/R9: word sweep through window, checked directly
    for (int t = 8; t < 256; t += 4) begin
      w = 32'h5A00_0000 | (t * 32'h0001_0203);
      access(1, 0, 2, t, rd, cyc);
      rc = regCount;
      access(1, 4, 2, w, rd, cyc);
      rfSh[t/4] = w;
      chk("R7 reg latency", cyc, 1);
      chk("R4 one reg write", regCount - rc, 1);
      access(0, AW'(t), 2, 0, rd, cyc);
      chk($sformatf("R9 direct read t=%0d", t), rd, rfSh[t/4]);
    end

    // R6: sub-word lanes through window and directly
    foreach (rfSh[i]) begin end
    for (int j = 0; j < 4; j++) begin
      int t;
      t = (j == 0) ? 8 : (j == 1) ? 12 : (j == 2) ? 128 : 252;
      for (int c = 0; c < 7; c++) begin
        int n, o;
        logic [1:0] sz;
        logic [31:0] msk;
        sz = (c < 4) ? 2'd0 : (c < 6) ? 2'd1 : 2'd2;
        o  = (c < 4) ? c : (c < 6) ? (c - 4) * 2 : 0;
        n  = nBytes(sz);
        msk = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1);
        w = 32'hC0DE_0000 ^ (t * 32'h11) ^ (c * 32'h0101_0101);
        access(1, 0, 2, t, rd, cyc);
        access(1, AW'(4 + o), sz, w, rd, cyc);
        rfSh[t/4] = (rfSh[t/4] & ~(msk << (8*o))) | ((w & msk) << (8*o));
        access(0, AW'(4 + o), sz, 0, rd, cyc);
        chk($sformatf("R6 window lane t=%0d o=%0d n=%0d", t, o, n), rd, w & msk);
        access(0, AW'(t), 2, 0, rd, cyc);
        chk("R6 word merge", rd, rfSh[t/4]);
        access(0, AW'(t + o), sz, 0, rd, cyc);
        chk("R9 direct lane read", rd, (rfSh[t/4] >> (8*o)) & msk);
      end
    end

    // R5/R8: refused pointers
    for (int p = 0; p <= 4; p += 4) begin
      access(1, 0, 2, p, rd, cyc);
      rc = regCount; mc = memCount;
      access(0, 6, 0, 0, rd, cyc);
      chk("R5 refused read zero", rd, 0);
      chk("R5 error set", {31'b0, errFlag}, 1);
      access(1, 4, 2, 32'hDEAD_BEEF, rd, cyc);
      chk("R5 no transaction", (regCount - rc) + (memCount - mc), 0);
      chk("R7 refused latency", cyc, 1);
      access(1, 0, 2, 8, rd, cyc);
      access(0, 4, 2, 0, rd, cyc);
      chk("R8 sticky over good access", {31'b0, errFlag}, 1);
      chk("R4 first accepted pointer", rd, rfSh[2]);
      access(0, 0, 2, 0, rd, cyc);
      chk("R1 index readback", rd, 8);
      chk("R8 cleared by index read", {31'b0, errFlag}, 0);
    end

    // R7: ready is a single pulse
    access(1, 0, 2, 16, rd, cyc);
    @(negedge clk);
    chk("R7 ready pulse ends", {31'b0, hostReady}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule